// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block keeps a bank of transmit mailboxes for a CAN controller and decides which pending frame is handed to the bit engine next. Software uses a word-addressed register port. It fills a mailbox with an identifier word, a control word and two data words. It then sets the mailbox's enable bit and sets its transmit-request bit through a write-one-to-set register. The identifier word follows the usual layout: bit 31 flags extended format, a standard identifier sits in bits [28:18], and an extended identifier fills bits [28:0]. The control word holds the length code in [3:0], the remote flag in bit 4 and a 6-bit send priority in [13:8].

While the bit engine is idle, the arbiter looks at every mailbox that is both enabled and requested. It picks the one whose priority field is numerically largest. When two priorities are equal, the higher mailbox number wins. The chosen frame is latched onto the engine port and held there until the engine reports completion. Completion sets the mailbox's acknowledge bit and drops its request. Software can withdraw a pending frame that has not started, and that sets an abort-acknowledge bit. Each acknowledge bit whose interrupt-mask bit is set raises the mailbox interrupt, which also reports a mailbox number.

Register map (word addresses, bit 8 clear): 0 enable, 1 transmit request (write-one-to-set, read gives pending bits), 2 abort request (write-one-to-set, reads zero), 3 transmit acknowledge (write-one-to-clear), 4 abort acknowledge (write-one-to-clear), 5 interrupt mask, 6 interrupt status (flag in bit 8, mailbox number in [4:0]). Addresses with bit 8 set select mailbox words: bits [6:2] give the mailbox and bits [1:0] the word (0 identifier, 1 control, 2 data low, 3 data high).

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset the enable, request, acknowledge, abort-acknowledge and mask registers read zero, eng_valid is 0 and irq is 0.
- R2: A mailbox word written while its enable bit is clear reads back unchanged; register reads return data one cycle after rd_en.
- R3: A write to any word of a mailbox whose enable bit is set is ignored.
- R4: A mailbox that is enabled and requested while the engine is idle is offered two clock edges after its request write: eng_valid rises and eng_mbx, eng_id, eng_ctrl, eng_dlo and eng_dhi show that mailbox's number and words.
- R5: Among candidates, the mailbox with the largest control-word priority field [13:8] is offered first.
- R6: Among candidates of equal priority, the highest-numbered mailbox is offered first.
- R7: While eng_valid is high the offered mailbox does not change, even if a higher-priority request arrives.
- R8: eng_done while eng_valid is high sets the mailbox's acknowledge bit, clears its request bit and drops eng_valid at the same edge; eng_done while idle has no effect.
- R9: Writing zeros to the request register clears nothing; writing ones to the acknowledge register clears exactly those bits.
- R10: An abort write clears each named request that is pending and not being offered, and sets its abort-acknowledge bit; the offered mailbox and non-pending mailboxes are unaffected. Abort-acknowledge bits are write-one-to-clear.
- R11: irq rises one edge after any acknowledge bit with its mask bit set becomes set. irq_mbx gives the highest such mailbox number, and the status word reports the same with the flag in bit 8. irq falls one edge after the last such bit clears.
- R12: A requested mailbox whose enable bit is clear is never offered and stays pending; enabling it makes it a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 9 | Register read word address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| eng_valid | output | 1 | A frame is offered to the bit engine |
| eng_mbx | output | 5 | Number of the offered mailbox |
| eng_id | output | 32 | Identifier word of the offered frame |
| eng_ctrl | output | 32 | Control word of the offered frame |
| eng_dlo | output | 32 | Low data word of the offered frame |
| eng_dhi | output | 32 | High data word of the offered frame |
| eng_done | input | 1 | Engine reports the offered frame sent |
| irq | output | 1 | Mailbox interrupt |
| irq_mbx | output | 5 | Mailbox number reported by the interrupt |

## Verification
Each result has a fixed cycle count. A request write shows on the engine port two edges after it is presented, so the bench checks that eng_valid is still low at the first sampling point and high at the second. Acknowledge and request bits change at the same edge that samples eng_done. The interrupt follows one edge later, so the bench samples irq once while it must still be low and once after it must be high. Register reads are sampled the cycle after the strobe. All samples are taken on the falling clock edge, and every draining loop waits exactly the one idle cycle between a completion and the next launch.

// File: rtl/tma_pkg.sv
package tma_pkg;
  localparam int WORD_W   = 32;
  localparam int PRIO_LSB = 8;

  localparam logic [2:0] GR_ENABLE = 3'd0;
  localparam logic [2:0] GR_REQ    = 3'd1;
  localparam logic [2:0] GR_ABORT  = 3'd2;
  localparam logic [2:0] GR_ACK    = 3'd3;
  localparam logic [2:0] GR_AACK   = 3'd4;
  localparam logic [2:0] GR_MASK   = 3'd5;
  localparam logic [2:0] GR_IRQ    = 3'd6;

  typedef enum logic [1:0] {
    MW_ID   = 2'd0,
    MW_CTRL = 2'd1,
    MW_DLO  = 2'd2,
    MW_DHI  = 2'd3
  } mword_e;

  typedef struct packed {
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] dlo;
    logic [WORD_W-1:0] dhi;
  } frame_t;
endpackage

// File: rtl/tma_regbank.sv
module tma_regbank
  import tma_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int PRIO_W = 6,
  parameter int ADDR_W = 9,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                done_evt,
  input  logic [IDX_W-1:0]    done_idx,
  input  logic [NUM_MB-1:0]   held_oh,
  input  logic                irq_q,
  input  logic [IDX_W-1:0]    irq_idx,
  input  logic [IDX_W-1:0]    fetch_idx,
  output frame_t              fetch_frame,
  output logic [NUM_MB-1:0]   en_q,
  output logic [NUM_MB-1:0]   req_q,
  output logic [NUM_MB-1:0]   ack_q,
  output logic [NUM_MB-1:0]   mask_q,
  output logic [PRIO_W-1:0]   prio_q [NUM_MB]
);
  localparam int DEPTH = NUM_MB * 4;

  logic [WORD_W-1:0] mb_mem [DEPTH];
  logic [NUM_MB-1:0] aack_q;

  logic              wr_mb, wr_g;
  logic [IDX_W-1:0]  wr_mbx;
  logic [1:0]        wr_word;
  logic [NUM_MB-1:0] wd, req_set, abort_w, abort_hit, ack_clr, aack_clr, done_oh;

  assign wr_mb   = wr_en && wr_addr[ADDR_W-1];
  assign wr_g    = wr_en && !wr_addr[ADDR_W-1];
  assign wr_mbx  = wr_addr[IDX_W+1:2];
  assign wr_word = wr_addr[1:0];
  assign wd      = wr_data[NUM_MB-1:0];

  always_comb begin
    req_set  = (wr_g && wr_addr[2:0] == GR_REQ)   ? wd : '0;
    abort_w  = (wr_g && wr_addr[2:0] == GR_ABORT) ? wd : '0;
    ack_clr  = (wr_g && wr_addr[2:0] == GR_ACK)   ? wd : '0;
    aack_clr = (wr_g && wr_addr[2:0] == GR_AACK)  ? wd : '0;
    done_oh  = done_evt ? ({{(NUM_MB-1){1'b0}}, 1'b1} << done_idx) : '0;
    abort_hit = abort_w & req_q & ~held_oh;
  end

  // mailbox storage: one write port, gated by the enable bit
  always_ff @(posedge clk) begin
    if (wr_mb && !en_q[wr_mbx])
      mb_mem[{wr_mbx, wr_word}] <= wr_data;
  end

  assign fetch_frame.id   = mb_mem[{fetch_idx, MW_ID}];
  assign fetch_frame.ctrl = mb_mem[{fetch_idx, MW_CTRL}];
  assign fetch_frame.dlo  = mb_mem[{fetch_idx, MW_DLO}];
  assign fetch_frame.dhi  = mb_mem[{fetch_idx, MW_DHI}];

  // parallel copy of the priority fields for the selector
  generate
    for (genvar g = 0; g < NUM_MB; g++) begin : g_prio
      always_ff @(posedge clk) begin
        if (rst)
          prio_q[g] <= '0;
        else if (wr_mb && wr_mbx == IDX_W'(g) && wr_word == MW_CTRL && !en_q[g])
          prio_q[g] <= wr_data[PRIO_LSB +: PRIO_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      req_q  <= '0;
      ack_q  <= '0;
      aack_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_g && wr_addr[2:0] == GR_ENABLE) en_q <= wd;
      if (wr_g && wr_addr[2:0] == GR_MASK)   mask_q <= wd;
      req_q  <= (req_q | req_set) & ~abort_hit & ~done_oh;
      ack_q  <= (ack_q & ~ack_clr) | done_oh;
      aack_q <= (aack_q & ~aack_clr) | abort_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr[ADDR_W-1]) begin
        rd_data <= mb_mem[{rd_addr[IDX_W+1:2], rd_addr[1:0]}];
      end else begin
        case (rd_addr[2:0])
          GR_ENABLE: rd_data <= WORD_W'(en_q);
          GR_REQ:    rd_data <= WORD_W'(req_q);
          GR_ACK:    rd_data <= WORD_W'(ack_q);
          GR_AACK:   rd_data <= WORD_W'(aack_q);
          GR_MASK:   rd_data <= WORD_W'(mask_q);
          GR_IRQ:    rd_data <= (WORD_W'(irq_q) << 8) | WORD_W'(irq_idx);
          default:   rd_data <= '0;
        endcase
      end
    end
  end

  // R8: a new acknowledge bit only appears after a completion
  a_r8_ack_from_done: assert property (@(posedge clk) disable iff (rst)
    ((ack_q & ~$past(ack_q)) != '0) |-> $past(done_evt));

  // R10: a new abort-acknowledge bit belongs to a mailbox that was pending
  a_r10_abort_was_pending: assert property (@(posedge clk) disable iff (rst)
    ((aack_q & ~$past(aack_q) & ~$past(req_q)) == '0));
endmodule

// File: rtl/tma_select.sv
module tma_select #(
  parameter int NUM_MB = 32,
  parameter int PRIO_W = 6,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0] en,
  input  logic [NUM_MB-1:0] req,
  input  logic [PRIO_W-1:0] prio [NUM_MB],
  output logic              any,
  output logic [IDX_W-1:0]  win_idx
);
  logic [NUM_MB-1:0] cand;
  logic [PRIO_W-1:0] best;

  assign cand = en & req;

  // ascending scan with >=: equal priority moves the winner upward
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (cand[i] && (!any || prio[i] >= best)) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        best    = prio[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      if (cand[i]) begin
        a_r5_top_prio: assert (prio[i] <= prio[win_idx]);
        a_r6_tie_high: assert (prio[i] != prio[win_idx] || i <= int'(win_idx));
      end
    end
  end
endmodule

// File: rtl/tma_launch.sv
module tma_launch
  import tma_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any,
  input  logic [IDX_W-1:0]   win_idx,
  input  frame_t             fetch_frame,
  input  logic               eng_done,
  output logic               eng_valid,
  output logic [IDX_W-1:0]   eng_mbx,
  output frame_t             eng_frame,
  output logic [NUM_MB-1:0]  held_oh,
  output logic               done_evt,
  output logic [IDX_W-1:0]   done_idx
);
  localparam logic [NUM_MB-1:0] ONE = {{(NUM_MB-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_valid <= 1'b0;
      eng_mbx   <= '0;
      eng_frame <= '0;
    end else if (!eng_valid) begin
      if (any) begin
        eng_valid <= 1'b1;
        eng_mbx   <= win_idx;
        eng_frame <= fetch_frame;
      end
    end else if (eng_done) begin
      eng_valid <= 1'b0;
    end
  end

  always_comb begin
    if (eng_valid)  held_oh = ONE << eng_mbx;
    else if (any)   held_oh = ONE << win_idx;
    else            held_oh = '0;
  end

  assign done_evt = eng_valid && eng_done;
  assign done_idx = eng_mbx;

  // R7: the offered mailbox stays locked until completion
  a_r7_locked: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_mbx)));
endmodule

// File: rtl/tma_irq.sv
module tma_irq #(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] ack,
  input  logic [NUM_MB-1:0] mask,
  output logic              irq_q,
  output logic [IDX_W-1:0]  irq_idx
);
  logic [NUM_MB-1:0] hit;
  logic [IDX_W-1:0]  top;

  assign hit = ack & mask;

  always_comb begin
    top = '0;
    for (int i = 0; i < NUM_MB; i++)
      if (hit[i]) top = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      irq_idx <= '0;
    end else begin
      irq_q   <= |hit;
      irq_idx <= top;
    end
  end

  // R11: the flag only follows a masked acknowledge
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(ack & mask) != '0));
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
  import tma_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int PRIO_W = 6,
  parameter int ADDR_W = 9,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              eng_valid,
  output logic [IDX_W-1:0]  eng_mbx,
  output logic [31:0]       eng_id,
  output logic [31:0]       eng_ctrl,
  output logic [31:0]       eng_dlo,
  output logic [31:0]       eng_dhi,
  input  logic              eng_done,
  output logic              irq,
  output logic [IDX_W-1:0]  irq_mbx
);
  logic [NUM_MB-1:0] en_q, req_q, ack_q, mask_q, held_oh;
  logic [PRIO_W-1:0] prio_q [NUM_MB];
  logic              any, done_evt;
  logic [IDX_W-1:0]  win_idx, done_idx;
  frame_t            fetch_frame, eng_frame;

  tma_regbank #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done_evt(done_evt), .done_idx(done_idx), .held_oh(held_oh),
    .irq_q(irq), .irq_idx(irq_mbx),
    .fetch_idx(win_idx), .fetch_frame(fetch_frame),
    .en_q(en_q), .req_q(req_q), .ack_q(ack_q), .mask_q(mask_q), .prio_q(prio_q)
  );

  tma_select #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) u_sel (
    .en(en_q), .req(req_q), .prio(prio_q), .any(any), .win_idx(win_idx)
  );

  tma_launch #(.NUM_MB(NUM_MB)) u_launch (
    .clk(clk), .rst(rst), .any(any), .win_idx(win_idx),
    .fetch_frame(fetch_frame), .eng_done(eng_done),
    .eng_valid(eng_valid), .eng_mbx(eng_mbx), .eng_frame(eng_frame),
    .held_oh(held_oh), .done_evt(done_evt), .done_idx(done_idx)
  );

  tma_irq #(.NUM_MB(NUM_MB)) u_irq (
    .clk(clk), .rst(rst), .ack(ack_q), .mask(mask_q),
    .irq_q(irq), .irq_idx(irq_mbx)
  );

  assign eng_id   = eng_frame.id;
  assign eng_ctrl = eng_frame.ctrl;
  assign eng_dlo  = eng_frame.dlo;
  assign eng_dhi  = eng_frame.dhi;

  // R10: the offered mailbox keeps its request until completion
  a_r10_offer_pending: assert property (@(posedge clk) disable iff (rst)
    eng_valid |-> req_q[eng_mbx]);
endmodule

// File: tb/sim_can_tx_arbiter.sv
`timescale 1ns/1ps
module sim_can_tx_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, eng_done = 1'b0;
  logic [8:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, eng_id, eng_ctrl, eng_dlo, eng_dhi;
  logic        eng_valid, irq;
  logic [4:0]  eng_mbx, irq_mbx;

  int n_run = 0, n_fail = 0;
  logic [31:0] en_m, req_m;
  logic [5:0]  prio_m [32];

  always #5 clk = ~clk;

  can_tx_arbiter u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_valid(eng_valid), .eng_mbx(eng_mbx), .eng_id(eng_id), .eng_ctrl(eng_ctrl),
    .eng_dlo(eng_dlo), .eng_dhi(eng_dhi), .eng_done(eng_done),
    .irq(irq), .irq_mbx(irq_mbx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] mba(int mb, int w);
    return {1'b1, 1'b0, 5'(mb), 2'(w)};
  endfunction

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // expected winner from the requirement: largest priority, then largest number
  function automatic int exp_winner();
    int w = -1;
    for (int i = 0; i < 32; i++)
      if (en_m[i] && req_m[i])
        if (w < 0 || prio_m[i] > prio_m[w] || (prio_m[i] == prio_m[w] && i > w)) w = i;
    return w;
  endfunction

  task automatic drain(string req);
    int w;
    while ((en_m & req_m) != 0) begin
      @(negedge clk);
      w = exp_winner();
      chk(req, {31'b0, eng_valid}, 32'd1);
      chk(req, {27'b0, eng_mbx}, 32'(w));
      done_pulse();
      req_m[w] = 1'b0;
    end
  endtask

  task automatic prog(int mb, logic [5:0] p);
    wr(mba(mb, 1), {18'b0, p, 8'h08});
    prio_m[mb] = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(9'(a), d);
      chk("R1", d, 32'd0);
    end
    chk("R1", {31'b0, eng_valid}, 0);
    chk("R1", {31'b0, irq}, 0);

    // R2 mailbox storage
    wr(mba(5, 0), 32'h123 << 18);
    wr(mba(5, 1), 32'h0000_0A08);
    wr(mba(5, 2), 32'hDEAD_BEEF);
    wr(mba(5, 3), 32'h0102_0304);
    rd(mba(5, 0), d); chk("R2", d, 32'h123 << 18);
    rd(mba(5, 1), d); chk("R2", d, 32'h0000_0A08);
    rd(mba(5, 3), d); chk("R2", d, 32'h0102_0304);

    // mailbox 9: priority 40, used for the lock test
    wr(mba(9, 0), 32'h8000_0000 | 32'h1ABCDEF);
    wr(mba(9, 1), 32'h0000_2808);

    // R3 writes ignored while enabled
    wr(9'h000, (32'd1 << 5) | (32'd1 << 9));
    wr(mba(5, 1), 32'h0000_3F01);
    rd(mba(5, 1), d); chk("R3", d, 32'h0000_0A08);

    // R4 launch timing and frame content
    wr(9'h001, 32'd1 << 5);
    chk("R4", {31'b0, eng_valid}, 0);
    @(negedge clk);
    chk("R4", {31'b0, eng_valid}, 1);
    chk("R4", {27'b0, eng_mbx}, 5);
    chk("R4", eng_id, 32'h123 << 18);
    chk("R4", eng_ctrl, 32'h0000_0A08);
    chk("R4", eng_dlo, 32'hDEAD_BEEF);
    chk("R4", eng_dhi, 32'h0102_0304);

    // R7 lock against a higher-priority arrival
    wr(9'h001, 32'd1 << 9);
    repeat (4) @(negedge clk);
    chk("R7", {27'b0, eng_mbx}, 5);
    chk("R7", {31'b0, eng_valid}, 1);

    // R10 abort: offered mailbox 5 kept, pending 9 withdrawn
    wr(9'h002, (32'd1 << 5) | (32'd1 << 9));
    rd(9'h001, d); chk("R10", d, 32'd1 << 5);
    rd(9'h004, d); chk("R10", d, 32'd1 << 9);
    chk("R10", {27'b0, eng_mbx}, 5);

    // R8 completion and R11 interrupt
    wr(9'h005, 32'd1 << 5);
    done_pulse();
    chk("R8", {31'b0, eng_valid}, 0);
    chk("R11", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R11", {31'b0, irq}, 1);
    chk("R11", {27'b0, irq_mbx}, 5);
    rd(9'h003, d); chk("R8", d, 32'd1 << 5);
    rd(9'h001, d); chk("R8", d, 32'd0);
    rd(9'h006, d); chk("R11", d, (32'd1 << 8) | 32'd5);

    // R9 acknowledge write-one-to-clear
    wr(9'h003, 32'd0);
    rd(9'h003, d); chk("R9", d, 32'd1 << 5);
    wr(9'h003, 32'd1 << 5);
    @(negedge clk);
    chk("R11", {31'b0, irq}, 0);
    rd(9'h003, d); chk("R9", d, 32'd0);

    // R8 completion while idle ignored
    done_pulse();
    rd(9'h003, d); chk("R8", d, 32'd0);
    chk("R8", {31'b0, eng_valid}, 0);

    // R10 abort-acknowledge clear
    wr(9'h004, 32'd1 << 9);
    rd(9'h004, d); chk("R10", d, 32'd0);

    // R12 disabled mailbox stays pending; R9 zero write to request
    wr(9'h000, 32'd0);
    wr(mba(20, 1), 32'h0000_3F08);
    wr(9'h001, 32'd1 << 20);
    repeat (3) @(negedge clk);
    chk("R12", {31'b0, eng_valid}, 0);
    wr(9'h001, 32'd0);
    rd(9'h001, d); chk("R9", d, 32'd1 << 20);
    wr(9'h000, 32'd1 << 20);
    @(negedge clk);
    chk("R12", {31'b0, eng_valid}, 1);
    chk("R12", {27'b0, eng_mbx}, 20);
    done_pulse();
    wr(9'h003, 32'hFFFF_FFFF);
    wr(9'h000, 32'd0);

    // R6 ties broken toward the higher number
    for (int i = 0; i < 32; i++) prio_m[i] = 6'd0;
    prog(2, 6'd33); prog(7, 6'd33); prog(11, 6'd33);
    en_m = (32'd1 << 2) | (32'd1 << 7) | (32'd1 << 11);
    req_m = en_m;
    wr(9'h000, en_m);
    wr(9'h001, req_m);
    drain("R6");
    wr(9'h003, 32'hFFFF_FFFF);

    // R5/R6/R12/R10 constrained random rounds
    for (int r = 0; r < 6; r++) begin
      wr(9'h000, 32'd0);
      for (int i = 0; i < 32; i++)
        prog(i, ($urandom % 2) ? 6'($urandom % 64) : 6'(36 + $urandom % 3));
      en_m  = $urandom | 32'h1;
      req_m = $urandom | 32'h1;
      wr(9'h000, en_m);
      wr(9'h001, req_m);
      drain("R5");
      @(negedge clk);
      chk("R12", {31'b0, eng_valid}, 0);
      rd(9'h001, d); chk("R12", d, req_m);
      wr(9'h002, 32'hFFFF_FFFF);
      rd(9'h004, d); chk("R10", d, req_m);
      rd(9'h001, d); chk("R10", d, 32'd0);
      wr(9'h003, 32'hFFFF_FFFF);
      wr(9'h004, 32'hFFFF_FFFF);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule